// File: doc/BRIEF.md
# Constant Off-Time Current Chopper

This block holds a motor winding current near a reference by chopping one active bridge pair. The source leg's upper switch stays on for the whole run. The sink leg's lower switch carries the drive current. A comparator input reports when the sensed current is above the reference. When that input is seen during the on phase, the lower switch opens. The current then freewheels through the two upper switches, which is slow decay. After one dead time, the sink leg's upper switch closes to rectify synchronously. An off timer, started at the trip, ends that interval. One more dead time then separates the upper switch opening from the lower switch closing again.

Dead time, blanking time, minimum on time and off time are counts of the system clock. The block samples them only while it is idle. A 20-bit count covers off times of several milliseconds at clock rates above 100 MHz. Short counts still allow chopping well above 100 kHz. When the enable input is low, every gate command goes low in the same cycle and the sequencer returns to idle.

Top module: `chop_pwm`

## Requirements
- R1: While rst_ni is low, src_hs_o, snk_hs_o and snk_ls_o are all low.
- R2: In any cycle where en_i is low, all three gate commands are low. After en_i rises, the outputs stay low for D cycles before the first on phase, where D = dead_cnt_i (minimum 1).
- R3: During the on phase, src_hs_o = 1, snk_ls_o = 1 and snk_hs_o = 0.
- R4: A trip is a high sense_i in an eligible on cycle. The next cycle opens snk_ls_o while src_hs_o stays high, so the current recirculates through the upper switches.
- R5: For the first B on cycles after every turn-on, sense_i is ignored, where B = blank_cnt_i. A pulse confined to that window leaves the on phase running.
- R6: The on phase lasts at least M cycles, where M = ton_min_i (minimum 1). With sense_i held high, the on phase lasts exactly max(B+1, M) cycles.
- R7: snk_hs_o rises D cycles after snk_ls_o falls. It stays high until the off timer ends, and the timer runs T cycles from the trip, where T = toff_cnt_i. The total time with snk_ls_o low before recovery is max(T, D+1) cycles.
- R8: After snk_hs_o falls, snk_ls_o rises again after D cycles. One chopping period is max(B+1,M) + max(T,D+1) + D cycles.
- R9: snk_hs_o and snk_ls_o are never high together. Either one rising needs the other to have been low in the previous cycle. Neither is high unless src_hs_o is high.
- R10: Configuration inputs changed while enabled have no effect until the block has passed through idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Bridge enable; low forces all gates off and returns to idle |
| sense_i | input | 1 | Current comparator, high when current exceeds reference |
| dead_cnt_i | input | CNT_W | Dead time in clock cycles |
| blank_cnt_i | input | CNT_W | Comparator blanking after turn-on, in cycles |
| ton_min_i | input | CNT_W | Minimum on time in cycles |
| toff_cnt_i | input | CNT_W | Off timer length from the trip, in cycles |
| src_hs_o | output | 1 | Source leg upper switch command |
| snk_hs_o | output | 1 | Sink leg upper switch command (synchronous rectifier) |
| snk_ls_o | output | 1 | Sink leg lower switch command |

## Verification
Several properties hold on every cycle and are checked that way. The sink leg never shoots through. A one-cycle gap always separates its two switches in either direction. The sink switches only conduct when the source switch does. Every gate is off the cycle after enable falls. The exact lengths of the on, dead, rectifying and recovery intervals can only be shown by the bench's sweeps, which derive them arithmetically from the programmed counts. The same holds for blanking a pulse, the minimum on time, and config changes being held off while running.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DT_ON,
    ST_ON,
    ST_DT_OFF,
    ST_SYNC,
    ST_DT_REC
  } chop_st_e;
endpackage

// File: rtl/chop_cnt.sv
// Loadable down counter: after load with N, done_o rises after N-1 run cycles.
module chop_cnt #(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         run_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= (val_i == '0) ? '0 : val_i - W'(1);
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/chop_onwin.sv
// On-phase window: counts on cycles, flags when blanking and min-on have elapsed.
module chop_onwin #(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic [W-1:0] blank_i,
  input  logic [W-1:0] ton_i,
  output logic         elig_o
);
  logic [W-1:0] k_q;
  logic [W:0]   k_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  k_q <= '0;
    else if (clr_i)               k_q <= '0;
    else if (run_i && k_q != '1)  k_q <= k_q + W'(1);
  end

  assign k_nx   = {1'b0, k_q} + (W+1)'(1);
  assign elig_o = (k_q >= blank_i) && (k_nx >= {1'b0, ton_i});
endmodule

// File: rtl/chop_pwm.sv
module chop_pwm
  import chop_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             sense_i,
  input  logic [CNT_W-1:0] dead_cnt_i,
  input  logic [CNT_W-1:0] blank_cnt_i,
  input  logic [CNT_W-1:0] ton_min_i,
  input  logic [CNT_W-1:0] toff_cnt_i,
  output logic             src_hs_o,
  output logic             snk_hs_o,
  output logic             snk_ls_o
);
  chop_st_e st_q, st_d;
  logic [CNT_W-1:0] dead_q, blank_q, ton_q, toff_q;
  logic ph_load, ph_run, ph_done;
  logic off_load, off_run, off_done;
  logic win_clr, win_elig;

  // configuration is sampled only while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dead_q  <= CNT_W'(1);
      blank_q <= '0;
      ton_q   <= CNT_W'(1);
      toff_q  <= CNT_W'(1);
    end else if (st_q == ST_IDLE) begin
      dead_q  <= dead_cnt_i;
      blank_q <= blank_cnt_i;
      ton_q   <= ton_min_i;
      toff_q  <= toff_cnt_i;
    end
  end

  always_comb begin
    st_d = st_q;
    if (!en_i) st_d = ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE:   st_d = ST_DT_ON;
        ST_DT_ON:  if (ph_done) st_d = ST_ON;
        ST_ON:     if (win_elig && sense_i) st_d = ST_DT_OFF;
        ST_DT_OFF: if (ph_done) st_d = ST_SYNC;
        ST_SYNC:   if (off_done) st_d = ST_DT_REC;
        ST_DT_REC: if (ph_done) st_d = ST_ON;
        default:   st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign ph_load  = (st_d != st_q) &&
                    (st_d == ST_DT_ON || st_d == ST_DT_OFF || st_d == ST_DT_REC);
  assign ph_run   = (st_q == ST_DT_ON || st_q == ST_DT_OFF || st_q == ST_DT_REC);
  assign off_load = (st_q == ST_ON) && (st_d == ST_DT_OFF);
  assign off_run  = (st_q == ST_DT_OFF || st_q == ST_SYNC);
  assign win_clr  = (st_d == ST_ON) && (st_q != ST_ON);

  chop_cnt #(.W(CNT_W)) u_ph (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ph_load), .val_i(dead_q),
    .run_i(ph_run), .done_o(ph_done)
  );

  // off timer spans dead-off and sync phases from the trip
  chop_cnt #(.W(CNT_W)) u_off (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(off_load), .val_i(toff_q),
    .run_i(off_run), .done_o(off_done)
  );

  chop_onwin #(.W(CNT_W)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(win_clr), .run_i(st_q == ST_ON),
    .blank_i(blank_q), .ton_i(ton_q), .elig_o(win_elig)
  );

  assign src_hs_o = en_i && (st_q == ST_ON || st_q == ST_DT_OFF ||
                             st_q == ST_SYNC || st_q == ST_DT_REC);
  assign snk_ls_o = en_i && (st_q == ST_ON);
  assign snk_hs_o = en_i && (st_q == ST_SYNC);
endmodule

// File: rtl/chop_pwm_chk.sv
module chop_pwm_chk #(
  parameter int CNT_W = 20
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic src_hs_o,
  input logic snk_hs_o,
  input logic snk_ls_o
);
  a_r9_leg_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(snk_hs_o && snk_ls_o));

  a_r9_gap_ls_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(snk_ls_o) |-> !$past(snk_hs_o));

  a_r7_gap_hs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(snk_hs_o) |-> !$past(snk_ls_o));

  a_r4_slow_decay_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snk_ls_o || snk_hs_o) |-> src_hs_o);

  a_r2_disable_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_i) |=> !(src_hs_o || snk_hs_o || snk_ls_o));
endmodule

bind chop_pwm chop_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
  .src_hs_o(src_hs_o), .snk_hs_o(snk_hs_o), .snk_ls_o(snk_ls_o)
);

// File: tb/sim_chop_pwm.sv
module sim_chop_pwm;
  localparam int W = 20;
  logic clk = 1'b0;
  logic rst_n;
  logic en, sense;
  logic [W-1:0] dead, blank, tonm, toff;
  logic src_hs, snk_hs, snk_ls;
  int vecs = 0;
  int errs = 0;

  always #4 clk = ~clk;

  chop_pwm #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sense_i(sense),
    .dead_cnt_i(dead), .blank_cnt_i(blank), .ton_min_i(tonm), .toff_cnt_i(toff),
    .src_hs_o(src_hs), .snk_hs_o(snk_hs), .snk_ls_o(snk_ls)
  );

  task automatic chk(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {src_hs, snk_hs, snk_ls};
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s t=%0t {src_hs,snk_hs,snk_ls} got %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic set_cfg(input int d, input int b, input int m, input int t);
    dead = W'(d); blank = W'(b); tonm = W'(m); toff = W'(t);
  endtask

  // expected {src_hs,snk_hs,snk_ls} at sample j after enable, with sense held high
  function automatic logic [2:0] exp_at(input int j, input int d, input int lon, input int tof);
    int p;
    if (j < d) return 3'b000;
    p = (j - d) % (lon + tof + d);
    if (p < lon)           return 3'b101;
    else if (p < lon + d)  return 3'b100;
    else if (p < lon + tof) return 3'b110;
    else                    return 3'b100;
  endfunction

  function automatic string tag_at(input int j, input int d, input int lon, input int tof);
    int p;
    if (j < d) return "R2";
    p = (j - d) % (lon + tof + d);
    if (p < lon)            return "R3 R6";
    else if (p < lon + d)   return "R4";
    else if (p < lon + tof) return "R7";
    else                    return "R8";
  endfunction

  task automatic run_pat(input int d, input int b, input int m, input int t,
                         input int nper, input bit swap);
    int lon, tof, n;
    en = 1'b0;
    set_cfg(d, b, m, t);
    repeat (3) @(negedge clk);
    lon = (b + 1 > m) ? b + 1 : m;
    tof = (t > d + 1) ? t : d + 1;
    n = nper * (lon + tof + d) + d + 2;
    sense = 1'b1;
    en = 1'b1;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      chk(swap ? {"R10 ", tag_at(j, d, lon, tof)} : tag_at(j, d, lon, tof),
          exp_at(j, d, lon, tof));
      if (swap && j == 0) set_cfg(3, 2, 4, 6);
    end
    en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errs++;
    $display("FAIL watchdog expired: got running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; sense = 1'b1;
    set_cfg(1, 0, 1, 1);
    repeat (4) @(negedge clk);
    chk("R1", 3'b000);
    @(negedge clk);
    chk("R1", 3'b000);
    en = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2", 3'b000);

    // sweep of timing configuration, sense held high
    for (int d = 1; d <= 3; d++)
      for (int b = 0; b <= 2; b++)
        for (int m = 1; m <= 4; m++)
          for (int t = 1; t <= 6; t++)
            run_pat(d, b, m, t, 2, 1'b0);

    // blanking: pulse inside the blank window is ignored (d=2,b=3,m=1,t=4)
    en = 1'b0; sense = 1'b0;
    set_cfg(2, 3, 1, 4);
    repeat (3) @(negedge clk);
    en = 1'b1;
    @(negedge clk); chk("R2", 3'b000);
    @(negedge clk); chk("R2", 3'b000);
    @(negedge clk); chk("R3", 3'b101); sense = 1'b1;   // s2, k=0
    @(negedge clk); chk("R5", 3'b101);                 // s3
    @(negedge clk); chk("R5", 3'b101);                 // s4
    @(negedge clk); chk("R5", 3'b101); sense = 1'b0;   // s5
    for (int j = 6; j <= 9; j++) begin
      @(negedge clk); chk("R5", 3'b101);
    end
    sense = 1'b1;                                       // trip seen during s9 cycle
    @(negedge clk); chk("R4", 3'b100);                 // s10
    @(negedge clk); chk("R4", 3'b100);                 // s11
    @(negedge clk); chk("R7", 3'b110);                 // s12
    @(negedge clk); chk("R7", 3'b110);                 // s13
    @(negedge clk); chk("R8", 3'b100);                 // s14
    @(negedge clk); chk("R8", 3'b100);                 // s15
    @(negedge clk); chk("R8", 3'b101);                 // s16
    repeat (3) @(negedge clk);                         // s17..s19
    chk("R6", 3'b101);
    @(negedge clk); chk("R4", 3'b100);                 // s20
    @(negedge clk);                                    // s21
    @(negedge clk); chk("R7", 3'b110);                 // s22
    en = 1'b0;
    #1 chk("R2", 3'b000);
    @(negedge clk); chk("R2", 3'b000);
    en = 1'b1;
    @(negedge clk); chk("R2", 3'b000);
    @(negedge clk); chk("R2", 3'b000);
    @(negedge clk); chk("R2", 3'b101);

    // config change while running is held off until idle
    run_pat(1, 0, 2, 3, 3, 1'b1);
    run_pat(3, 2, 4, 6, 1, 1'b1);

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule